// File: doc/BRIEF.md
# Software-Paced I2C Master

This block is an I2C master for a single target. Software controls it through a small register bus. It drives SCL and SDA as open-drain lines, so each output is an enable: 1 pulls the line low and 0 releases it. There are four registers: control, status, target address and one data register shared by transmit and receive. Software writes the target address with its direction bit, then sets the enable and start bits. The block sends a START followed by the address byte.

At the end of every phase the block stops with SCL held low and raises a status flag. The bus stays frozen until software writes that flag to 0. A write transfer sends the data register each time software clears the data-empty flag. A read transfer captures a byte into the data register before it raises the received flag. If force-stop is set when software releases the last stall, a STOP follows. The block also reports a target that does not acknowledge and a lost arbitration. A pin-override mode lets software drive both lines by hand.

Top module: `i2c_master`

## Requirements
- R1: After reset all four registers read 0 and both line enables (`sclOe`, `sdaOe`) are 0.
- R2: Register select codes are 0 control, 1 status, 2 address, 3 data. Control bits: 7 mode (stored only), 6 SCL level in override, 5 SDA level in override, 4 override, 3 enable, 2 reserved (reads 0), 1 force-stop, 0 start. Status bits: 6 target-NACK, 5 arbitration-lost, 4 stop-done, 3 data-empty, 2 byte-sent, 1 byte-received, 0 address-done. Status bit 7 reads 0.
- R3: A control write with enable=1, start=1 and override=0, made while idle, makes a START (SDA falls while SCL is high). The address register byte then goes out MSB first. Address bit 0 is the direction: 1 means read.
- R4: In a write, once the target acknowledges the address, status reads 0x09 and SCL is held low until software clears bit 3.
- R5: A status write clears each bit written as 0 and keeps each bit written as 1. If a hardware flag set and a software clear of that bit fall in the same cycle, the set wins.
- R6: In a write, clearing data-empty with force-stop at 0 sends the data register byte MSB first. After the target acknowledges, bits 3 and 2 are set.
- R7: If force-stop is 1 when the stall that follows the last byte is released, the block makes a STOP (SDA rises while SCL is high), sets bit 4 and releases both lines.
- R8: In a read, once the address is acknowledged the first byte is received at once. It is stored in the data register and bits 0 and 1 are set. If a capture and a software write to the data register fall in the same cycle, the captured byte wins.
- R9: At the end of each received byte the master answers NACK if force-stop is 1 at that time, and ACK otherwise. Clearing bit 1 after an ACKed byte receives the next byte, with bit 1 alone set after it. Clearing bit 1 after a NACKed byte makes a STOP.
- R10: If the target does not acknowledge, bit 6 is set and SCL is held low. The block waits until force-stop is set, then makes a STOP.
- R11: If SDA reads low while the master is releasing it on an address or transmitted data bit, bit 5 is set, both lines are released and the block goes idle.
- R12: A control write with enable=0 and override=0 returns the block to idle. Both lines are released from the next cycle.
- R13: With override=1, `sclOe` is the inverse of control bit 6 and `sdaOe` is the inverse of control bit 5. A start request is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regSel | input | 2 | Register select |
| regWr | input | 1 | Write strobe for the selected register |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data of the selected register (combinational) |
| sdaIn | input | 1 | Sampled level of the SDA line |
| sclOe | output | 1 | 1 pulls SCL low |
| sdaOe | output | 1 | 1 pulls SDA low |

## Verification
Two pairs of actions can land in the same cycle. The first is a hardware flag set against a software status clear. The second is a byte capture against a software write to the data register. The bench forces each collision by writing every cycle: it clears status while a transmitted byte finishes, and it writes 0xEE to the data register while a byte is received. It stops writing as soon as the readback shows the hardware's value. It then requires status 0x0C in the first case and the target's byte in the second.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd1;
  localparam logic [1:0] SEL_ADDR = 2'd2;
  localparam logic [1:0] SEL_DATA = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_STA1, ST_STA2, ST_BIT, ST_STALL, ST_STO1, ST_STO2, ST_STO3
  } ctrlState_t;

  typedef enum logic [1:0] {WAIT_EMPTY, WAIT_RX, WAIT_STOP} waitKind_t;

  // control -> datapath
  typedef struct packed {
    logic loadAddr;
    logic loadData;
    logic sample;
    logic shift;
    logic capture;
    logic setNack;
    logic setArb;
    logic setStop;
    logic setEmpty;
    logic setTx;
    logic setRx;
    logic setAddr;
  } strobe_t;

  // datapath -> control
  typedef struct packed {
    logic startCmd;
    logic abortCmd;
  } cmd_t;
endpackage

// File: rtl/i2cm_datapath.sv
module i2cm_datapath
  import i2cm_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regSel,
  input  logic              regWr,
  input  logic [BYTE_W-1:0] regWdata,
  output logic [BYTE_W-1:0] regRdata,
  input  strobe_t           stb,
  input  logic              sdaIn,
  output cmd_t              cmd,
  output logic [BYTE_W-1:0] ctrlBits,
  output logic [6:0]        statBits,
  output logic              txBit,
  output logic              rxBit,
  output logic              dirRead
);
  localparam logic [BYTE_W-1:0] CTRL_MASK = BYTE_W'(8'hFB);

  logic [BYTE_W-1:0] ctrlReg, addrReg, dataReg, shiftReg;
  logic [6:0]        statReg, statSet, statNext;
  logic              sampBit;

  assign statSet = {stb.setNack, stb.setArb, stb.setStop, stb.setEmpty,
                    stb.setTx, stb.setRx, stb.setAddr};

  always_comb begin
    statNext = statReg;
    if (regWr && regSel == SEL_STAT) statNext = statNext & regWdata[6:0];
    statNext = statNext | statSet;   // hardware set wins
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      addrReg  <= '0;
      dataReg  <= '0;
      shiftReg <= '0;
      statReg  <= '0;
      sampBit  <= 1'b1;
    end else begin
      statReg <= statNext;
      if (regWr && regSel == SEL_CTRL) ctrlReg <= regWdata & CTRL_MASK;
      if (regWr && regSel == SEL_ADDR) addrReg <= regWdata;
      if (stb.capture) dataReg <= shiftReg;
      else if (regWr && regSel == SEL_DATA) dataReg <= regWdata;
      if (stb.sample) sampBit <= sdaIn;
      if (stb.loadAddr) shiftReg <= addrReg;
      else if (stb.loadData) shiftReg <= dataReg;
      else if (stb.shift) shiftReg <= {shiftReg[BYTE_W-2:0], sampBit};
    end
  end

  always_comb begin
    unique case (regSel)
      SEL_CTRL: regRdata = ctrlReg;
      SEL_STAT: regRdata = BYTE_W'(statReg);
      SEL_ADDR: regRdata = addrReg;
      default:  regRdata = dataReg;
    endcase
  end

  assign cmd.startCmd = regWr && regSel == SEL_CTRL && regWdata[3] && regWdata[0] && !regWdata[4];
  assign cmd.abortCmd = regWr && regSel == SEL_CTRL && (!regWdata[3] || regWdata[4]);
  assign ctrlBits = ctrlReg;
  assign statBits = statReg;
  assign txBit    = shiftReg[BYTE_W-1];
  assign rxBit    = sampBit;
  assign dirRead  = addrReg[0];
endmodule

// File: rtl/i2cm_ctrl.sv
module i2cm_ctrl
  import i2cm_pkg::*;
#(
  parameter int unsigned QUARTER_CYCLES = 4,
  parameter int unsigned BYTE_W = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  cmd_t    cmd,
  input  logic    ovr,
  input  logic    frcScl,
  input  logic    frcSda,
  input  logic    forceStop,
  input  logic    emptyFlag,
  input  logic    rxFlag,
  input  logic    txBit,
  input  logic    rxBit,
  input  logic    dirRead,
  input  logic    sdaIn,
  output strobe_t stb,
  output logic    sclOe,
  output logic    sdaOe
);
  localparam int unsigned DIV_W = (QUARTER_CYCLES > 1) ? $clog2(QUARTER_CYCLES) : 1;
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ACK_SLOT  = CNT_W'(BYTE_W);

  ctrlState_t       state, stateN;
  waitKind_t        waitKind, waitN;
  logic [DIV_W-1:0] divCnt;
  logic [1:0]       quarter, quarterN;
  logic [CNT_W-1:0] bitCnt, bitCntN;
  logic isAddr, isAddrN, isRead, isReadN, mNack, mNackN, firstRx, firstRxN, startPend, startPendN;
  logic tick, txPhase;

  assign tick    = divCnt == DIV_W'(QUARTER_CYCLES - 1);
  assign txPhase = isAddr || !isRead;

  always_comb begin
    stateN = state; waitN = waitKind; quarterN = quarter; bitCntN = bitCnt;
    isAddrN = isAddr; isReadN = isRead; mNackN = mNack; firstRxN = firstRx;
    startPendN = startPend; stb = '0;
    if (state == ST_IDLE && cmd.startCmd) startPendN = 1'b1;
    if (tick) begin
      unique case (state)
        ST_IDLE: if (startPend) begin stateN = ST_STA1; startPendN = 1'b0; end
        ST_STA1: stateN = ST_STA2;
        ST_STA2: begin
          stateN = ST_BIT; quarterN = 2'd0; bitCntN = '0; isAddrN = 1'b1;
          isReadN = dirRead; mNackN = 1'b0; firstRxN = 1'b1; stb.loadAddr = 1'b1;
        end
        ST_BIT: begin
          quarterN = quarter + 2'd1;
          if (quarter == 2'd2) begin
            stb.sample = 1'b1;
            if (txPhase && bitCnt < ACK_SLOT && txBit && !sdaIn) begin
              stb.setArb = 1'b1; stateN = ST_IDLE;
            end
          end
          if (quarter == 2'd3) begin
            if (bitCnt < ACK_SLOT) begin
              stb.shift = 1'b1;
              bitCntN = bitCnt + 1'b1;
              if (bitCnt == LAST_DATA && !txPhase) mNackN = forceStop;
            end else begin
              bitCntN = '0;
              if (txPhase) begin
                if (rxBit) begin
                  stb.setNack = 1'b1; stateN = ST_STALL; waitN = WAIT_STOP;
                end else if (isAddr && isRead) begin
                  isAddrN = 1'b0;
                end else begin
                  stb.setEmpty = 1'b1; stb.setAddr = isAddr; stb.setTx = !isAddr;
                  isAddrN = 1'b0; stateN = ST_STALL; waitN = WAIT_EMPTY;
                end
              end else begin
                stb.capture = 1'b1; stb.setRx = 1'b1; stb.setAddr = firstRx;
                firstRxN = 1'b0; stateN = ST_STALL; waitN = WAIT_RX;
              end
            end
          end
        end
        ST_STALL: begin
          unique case (waitKind)
            WAIT_EMPTY: if (!emptyFlag) begin
              if (forceStop) stateN = ST_STO1;
              else begin stateN = ST_BIT; quarterN = 2'd0; stb.loadData = 1'b1; end
            end
            WAIT_RX: if (!rxFlag) begin
              if (mNack) stateN = ST_STO1;
              else begin stateN = ST_BIT; quarterN = 2'd0; end
            end
            default: if (forceStop) stateN = ST_STO1;
          endcase
        end
        ST_STO1: stateN = ST_STO2;
        ST_STO2: stateN = ST_STO3;
        default: begin stateN = ST_IDLE; stb.setStop = 1'b1; end
      endcase
    end
    if (cmd.abortCmd) begin stateN = ST_IDLE; startPendN = 1'b0; stb = '0; end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE; waitKind <= WAIT_STOP; divCnt <= '0; quarter <= '0;
      bitCnt <= '0; isAddr <= 1'b0; isRead <= 1'b0; mNack <= 1'b0;
      firstRx <= 1'b0; startPend <= 1'b0;
    end else begin
      state <= stateN; waitKind <= waitN; quarter <= quarterN; bitCnt <= bitCntN;
      isAddr <= isAddrN; isRead <= isReadN; mNack <= mNackN; firstRx <= firstRxN;
      startPend <= startPendN;
      divCnt <= tick ? '0 : divCnt + 1'b1;
    end
  end

  always_comb begin
    sclOe = 1'b0; sdaOe = 1'b0;
    unique case (state)
      ST_STA1: sdaOe = 1'b1;
      ST_STA2, ST_STO1: begin sclOe = 1'b1; sdaOe = 1'b1; end
      ST_STO2: sdaOe = 1'b1;
      ST_STALL: sclOe = 1'b1;
      ST_BIT: begin
        sclOe = (quarter == 2'd0) || (quarter == 2'd3);
        if (bitCnt < ACK_SLOT) sdaOe = txPhase && !txBit;
        else sdaOe = !txPhase && !mNack;
      end
      default: ;
    endcase
    if (ovr) begin sclOe = !frcScl; sdaOe = !frcSda; end
  end
endmodule

// File: rtl/i2c_master.sv
module i2c_master
  import i2cm_pkg::*;
#(
  parameter int unsigned QUARTER_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] regSel,
  input  logic       regWr,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  input  logic       sdaIn,
  output logic       sclOe,
  output logic       sdaOe
);
  strobe_t    stb;
  cmd_t       cmd;
  logic [7:0] ctrlBits;
  logic [6:0] statBits;
  logic       txBit, rxBit, dirRead;

  i2cm_datapath #(.BYTE_W(8)) u_dp (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr), .regWdata(regWdata),
    .regRdata(regRdata), .stb(stb), .sdaIn(sdaIn), .cmd(cmd), .ctrlBits(ctrlBits),
    .statBits(statBits), .txBit(txBit), .rxBit(rxBit), .dirRead(dirRead)
  );

  i2cm_ctrl #(.QUARTER_CYCLES(QUARTER_CYCLES), .BYTE_W(8)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmd(cmd), .ovr(ctrlBits[4]), .frcScl(ctrlBits[6]),
    .frcSda(ctrlBits[5]), .forceStop(ctrlBits[1]), .emptyFlag(statBits[3]),
    .rxFlag(statBits[1]), .txBit(txBit), .rxBit(rxBit), .dirRead(dirRead),
    .sdaIn(sdaIn), .stb(stb), .sclOe(sclOe), .sdaOe(sdaOe)
  );
endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] regSel,
  input logic       regWr,
  input logic [7:0] regWdata,
  input logic       sclOe,
  input logic       sdaOe,
  input logic       ovr,
  input logic       frcScl,
  input logic       frcSda,
  input logic [6:0] stat
);
  assert_idle_release_R12: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regSel == 2'd0 && !regWdata[3] && !regWdata[4]) |=> (!sclOe && !sdaOe));

  assert_override_R13: assert property (@(posedge clk) disable iff (!rstN)
    ovr |-> (sclOe == !frcScl && sdaOe == !frcSda));

  assert_stall_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!ovr && ($rose(stat[3]) || $rose(stat[1]) || $rose(stat[6]))) |-> sclOe);

  assert_keep_ones_R5: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regSel == 2'd1 && regWdata[6:0] == 7'h7F) |=> ((stat & $past(stat)) == $past(stat)));

  assert_stop_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!ovr && $rose(stat[4])) |-> (!sclOe && !sdaOe));

  assert_arb_release_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!ovr && $rose(stat[5])) |-> (!sclOe && !sdaOe));
endmodule

bind i2c_master i2cm_checker u_chk (
  .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr), .regWdata(regWdata),
  .sclOe(sclOe), .sdaOe(sdaOe), .ovr(ctrlBits[4]), .frcScl(ctrlBits[6]),
  .frcSda(ctrlBits[5]), .stat(statBits)
);

// File: tb/i2c_master_bench.sv
module i2c_master_bench;
  logic clk = 1'b0, rstN = 1'b0;
  logic [1:0] regSel = '0;
  logic regWr = 1'b0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic sclOe, sdaOe, sdaIn;
  logic slvOe = 1'b0, rogue = 1'b0;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  assign sdaIn = !(sdaOe || slvOe || rogue);

  i2c_master u_i2c_master (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr), .regWdata(regWdata),
    .regRdata(regRdata), .sdaIn(sdaIn), .sclOe(sclOe), .sdaOe(sdaOe)
  );

  // behavioural target at 7-bit address 0x50
  localparam logic [6:0] TGT = 7'h50;
  logic [7:0] wrQ[$], rdQ[$], ackQ[$];
  logic [7:0] lastAddr = '0, shReg = '0, curByte = '0;
  int startCnt = 0, stopCnt = 0, bitIdx = 0;
  bit active = 0, skipFall = 0, addrAck = 0, isRd = 0, slvTx = 0, wasAddr = 0;
  logic pScl = 1'b1, pSda = 1'b1;

  always @(negedge clk) begin
    logic sclL, sdaL;
    sclL = !sclOe;
    sdaL = sdaIn;
    if (!rstN) begin
      active = 0; slvOe = 1'b0;
    end else if (pScl && sclL && pSda && !sdaL) begin
      startCnt++; active = 1; skipFall = 1; bitIdx = 0; wasAddr = 1; slvTx = 0; slvOe = 1'b0;
    end else if (pScl && sclL && !pSda && sdaL) begin
      stopCnt++; active = 0; slvOe = 1'b0;
    end else if (active && !pScl && sclL) begin
      if (bitIdx < 8) shReg = {shReg[6:0], sdaL};
      else if (slvTx) ackQ.push_back({7'b0, sdaL});
    end else if (active && pScl && !sclL) begin
      if (skipFall) skipFall = 0;
      else begin
        bitIdx++;
        if (bitIdx == 8) begin
          if (!slvTx) begin
            if (wasAddr) begin
              lastAddr = shReg; addrAck = (shReg[7:1] == TGT); isRd = shReg[0]; slvOe = addrAck;
            end else if (addrAck) begin
              wrQ.push_back(shReg); slvOe = 1'b1;
            end
          end else slvOe = 1'b0;
        end else if (bitIdx == 9) begin
          bitIdx = 0;
          slvTx = isRd && addrAck && (wasAddr || (ackQ.size() > 0 && ackQ[$] == 8'h00));
          wasAddr = 0;
          if (slvTx) begin
            curByte = (rdQ.size() > 0) ? rdQ.pop_front() : 8'hFF;
            slvOe = !curByte[7];
          end else slvOe = 1'b0;
        end else if (slvTx) slvOe = !curByte[7-bitIdx];
      end
    end
    pScl = sclL; pSda = sdaIn;
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk); regSel = sel; regWdata = d; regWr = 1'b1;
    @(negedge clk); regWr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [7:0] v);
    @(negedge clk); regSel = sel; #1; v = regRdata;
  endtask

  task automatic waitBit(input int idx, input string req);
    logic [7:0] v;
    bit ok = 0;
    for (int i = 0; i < 4000; i++) begin
      rd(2'd1, v);
      if (v[idx]) begin ok = 1; break; end
    end
    chk({req, " flag wait"}, {7'b0, ok}, 8'h01);
  endtask

  task automatic holdLow(input string req);
    bit ok = 1;
    repeat (24) @(negedge clk) if (!sclOe) ok = 0;
    chk({req, " SCL held low"}, {7'b0, ok}, 8'h01);
  endtask

  initial begin
    repeat (2000) begin
      repeat (75) @(posedge clk);
    end
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int sc, ec;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    for (int s = 0; s < 4; s++) begin rd(2'(s), v); chk("R1 register", v, 8'h00); end
    chk("R1 lines", {6'b0, sclOe, sdaOe}, 8'h00);

    // write transfer
    sc = startCnt; ec = stopCnt;
    wr(2'd2, 8'hA0); wr(2'd3, 8'h3C); wr(2'd0, 8'h89);
    waitBit(3, "R4");
    rd(2'd1, v); chk("R4 status after address", v, 8'h09);
    chk("R3 START seen", 8'(startCnt - sc), 8'h01);
    chk("R3 address byte", lastAddr, 8'hA0);
    holdLow("R4");
    wr(2'd1, 8'hFF); rd(2'd1, v); chk("R5 write ones keeps", v, 8'h09);
    // collision: clear status every cycle until hardware sets empty again
    begin
      int n = 0;
      forever begin
        @(negedge clk); regSel = 2'd1; regWdata = 8'h00; regWr = 1'b1; #1;
        if (n > 0 && regRdata[3]) break;
        if (n > 4000) break;
        n++;
      end
      regWr = 1'b0; v = regRdata;
    end
    chk("R5 set wins over clear", v, 8'h0C);
    chk("R6 byte count", 8'(wrQ.size()), 8'h01);
    if (wrQ.size() > 0) chk("R6 byte sent", wrQ.pop_front(), 8'h3C);
    wr(2'd0, 8'h8A); wr(2'd1, 8'h00);
    waitBit(4, "R7");
    rd(2'd1, v); chk("R7 status after stop", v, 8'h10);
    chk("R7 STOP seen", 8'(stopCnt - ec), 8'h01);
    chk("R7 lines released", {6'b0, sclOe, sdaOe}, 8'h00);

    // two-byte read
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    rdQ.push_back(8'h5A); rdQ.push_back(8'hC3); ackQ.delete();
    wr(2'd2, 8'hA1); wr(2'd0, 8'h89);
    waitBit(1, "R8");
    rd(2'd1, v); chk("R8 status after first byte", v, 8'h03);
    rd(2'd3, v); chk("R8 first byte", v, 8'h5A);
    chk("R9 ACK on first byte", (ackQ.size() > 0) ? ackQ[0] : 8'hEE, 8'h00);
    holdLow("R8");
    wr(2'd0, 8'h8A); wr(2'd1, 8'h7C);
    begin
      int n = 0;
      forever begin
        @(negedge clk); regSel = 2'd3; regWdata = 8'hEE; regWr = 1'b1; #1;
        if (n > 0 && regRdata != 8'hEE) break;
        if (n > 4000) break;
        n++;
      end
      regWr = 1'b0; v = regRdata;
    end
    chk("R8 capture wins over write", v, 8'hC3);
    rd(2'd1, v); chk("R9 status after second byte", v, 8'h02);
    chk("R9 NACK on last byte", (ackQ.size() > 1) ? ackQ[1] : 8'hEE, 8'h01);
    wr(2'd1, 8'h00);
    waitBit(4, "R9");
    rd(2'd1, v); chk("R9 stop after NACKed byte", v, 8'h10);

    // single read with stop requested up front
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    rdQ.push_back(8'h96); ackQ.delete();
    wr(2'd0, 8'h8B);
    waitBit(1, "R8");
    rd(2'd1, v); chk("R8 single read status", v, 8'h03);
    rd(2'd3, v); chk("R8 single read byte", v, 8'h96);
    chk("R9 NACK when stop pending", (ackQ.size() > 0) ? ackQ[0] : 8'hEE, 8'h01);
    wr(2'd1, 8'h00);
    waitBit(4, "R7");
    rd(2'd1, v); chk("R7 single read stop", v, 8'h10);

    // target NACK
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    wr(2'd2, 8'hB0); wr(2'd0, 8'h89);
    waitBit(6, "R10");
    rd(2'd1, v); chk("R10 NACK status", v, 8'h40);
    holdLow("R10");
    wr(2'd0, 8'h8A);
    waitBit(4, "R10");
    rd(2'd1, v); chk("R10 stop after NACK", v, 8'h50);

    // arbitration loss
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    wr(2'd2, 8'hA0); sc = startCnt; wr(2'd0, 8'h89);
    for (int i = 0; i < 400 && startCnt == sc; i++) @(negedge clk);
    rogue = 1'b1;
    waitBit(5, "R11");
    rd(2'd1, v); chk("R11 arbitration status", v, 8'h20);
    chk("R11 lines released", {6'b0, sclOe, sdaOe}, 8'h00);
    rogue = 1'b0;
    repeat (60) @(negedge clk);
    chk("R11 stays idle", {6'b0, sclOe, sdaOe}, 8'h00);

    // abort from a stall
    wr(2'd1, 8'h00); wr(2'd0, 8'h89);
    waitBit(3, "R12");
    wr(2'd0, 8'h00);
    chk("R12 abort releases", {6'b0, sclOe, sdaOe}, 8'h00);
    repeat (40) @(negedge clk);
    chk("R12 idle holds", {6'b0, sclOe, sdaOe}, 8'h00);

    // pin override
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h10); chk("R13 both forced low", {6'b0, sclOe, sdaOe}, 8'h03);
    wr(2'd0, 8'h50); chk("R13 SCL high SDA low", {6'b0, sclOe, sdaOe}, 8'h01);
    wr(2'd0, 8'h30); chk("R13 SCL low SDA high", {6'b0, sclOe, sdaOe}, 8'h02);
    wr(2'd0, 8'hFF); rd(2'd0, v); chk("R2 reserved bit reads 0", v, 8'hFB);
    wr(2'd0, 8'h19);
    repeat (80) @(negedge clk);
    rd(2'd1, v); chk("R13 start ignored", v, 8'h00);
    chk("R13 lines while start ignored", {6'b0, sclOe, sdaOe}, 8'h03);
    wr(2'd0, 8'h00);
    chk("R2 control cleared", {6'b0, sclOe, sdaOe}, 8'h00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule